// File: doc/BRIEF.md
# Phase-Triggered Programmable Pulse Generator

This block produces one programmable timing waveform for a display panel timing controller. Several copies sit side by side, and each copy can see the outputs of the others. A 16-bit local counter is armed when a chosen line phase starts while the scan is inside a chosen frame phase. A global position counter can also be required to equal a programmed start value. Once it is running, the local counter advances on a selectable tick. The generator output goes active when the count equals the set value and inactive when it equals the clear value.

The generator output can be mixed with a neighbouring generator's output before it leaves the block. The mix either passes the neighbour through, ANDs or ORs the two, or ANDs the neighbour with a one-cycle marker of the arming instant. An enable bit and a polarity bit act on the final registered output.

Top module: `pgen_top`

## Requirements
- R1: While `rst` is high, `sig_out` is at the inactive level, which is the inverse of `cfg_pol`. Reset also returns the local counter to idle.
- R2: `cfg_start_mask` bits [3:0] qualify `frame_phase` bits [3:0] (sync, begin, data, end). Bits [7:4] qualify `line_phase` bits [3:0] in the same order. A start occurs only when a qualified `line_phase` bit rises (high now, low in the previous cycle) while at least one qualified `frame_phase` bit is high.
- R3: `cfg_gsel` values 0 to 7 select slot k = `cfg_gsel` of `gcnt_bus` (bits [12k+11:12k]), and a start needs that slot to equal `cfg_start_cnt`. Values 8 to 15 drop this condition.
- R4: `cfg_tick` 0 advances the counter on `pix_stb`, 1 on `line_start`, 2 on `frame_start`, and 3 on a rising edge of the selected neighbour signal. A start clears the counter to 0 and is not itself counted.
- R5: The generator signal becomes active in the cycle after a running counter is seen equal to `cfg_set`. It becomes inactive in the cycle after the counter is seen equal to `cfg_clr`, and the clear wins when both match. `sig_out` follows one cycle later.
- R6: The match on `cfg_clr` stops the counter. Only a later start re-arms it, and a start seen while the counter runs is ignored. The counter holds at 0xFFFF rather than wrapping.
- R7: `cfg_mix` 0 passes the neighbour signal through, 1 ANDs the generator signal with it, 2 ORs them, and 3 ANDs a one-cycle start marker with the neighbour. The output is registered, so `sig_out` reflects the neighbour value one cycle late.
- R8: The neighbour signal is `peer_sig[cfg_peer_sel]`.
- R9: When `cfg_en` is low, `sig_out` is at the inactive level from the next cycle on, and the counter is held at zero and idle.
- R10: With `cfg_pol` = 1 the output is active high. With `cfg_pol` = 0 the active value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_stb | input | 1 | Pixel clock strobe |
| line_start | input | 1 | Line start pulse |
| frame_start | input | 1 | Frame start pulse |
| frame_phase | input | 4 | Frame phase flags: sync, begin, data, end |
| line_phase | input | 4 | Line phase flags: sync, begin, data, end |
| gcnt_bus | input | 96 | Eight global counter values, 12 bits each |
| peer_sig | input | 32 | Outputs of neighbouring generators |
| cfg_en | input | 1 | Generator enable |
| cfg_pol | input | 1 | Output polarity, 1 = active high |
| cfg_tick | input | 2 | Tick source code |
| cfg_gsel | input | 4 | Global counter select, 8 to 15 = none |
| cfg_start_cnt | input | 12 | Global counter start value |
| cfg_start_mask | input | 8 | Frame/line phase start mask |
| cfg_set | input | 16 | Count that activates the signal |
| cfg_clr | input | 16 | Count that deactivates the signal and stops counting |
| cfg_mix | input | 2 | Output mix code |
| cfg_peer_sel | input | 5 | Neighbour signal index |
| sig_out | output | 1 | Registered generator output |

## Verification
On every cycle, the assertions check several rules. A disabled generator keeps its counter idle at zero and drives the inactive level. A clear match stops the counter and drops the signal. A running counter parked at 0xFFFF stays there. The counter only starts running after an accepted start event, and the AND mix with a low neighbour yields an inactive output. Some behaviour is only shown by the bench's scenarios and its cycle-level reference model: the exact pulse width for each tick source, rejection of starts by the phase mask or the global counter, the absence of a restart while running, re-arming, neighbour selection, and the start-marker mix.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int NUM_GSRC = 8;
  localparam int GSEL_W   = 4;
  localparam int PHASE_W  = 4;

  typedef enum logic [1:0] {
    TICK_PIX   = 2'd0,
    TICK_LINE  = 2'd1,
    TICK_FRAME = 2'd2,
    TICK_PEER  = 2'd3
  } tick_src_e;

  typedef enum logic [1:0] {
    MIX_PASS     = 2'd0,
    MIX_AND      = 2'd1,
    MIX_OR       = 2'd2,
    MIX_STARTAND = 2'd3
  } mix_op_e;
endpackage

// File: rtl/pgen_arm.sv
module pgen_arm
  import pgen_pkg::*;
#(
  parameter int GCNT_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PHASE_W-1:0]         frame_phase,
  input  logic [PHASE_W-1:0]         line_phase,
  input  logic [2*PHASE_W-1:0]       start_mask,
  input  logic [GSEL_W-1:0]          gsel,
  input  logic [NUM_GSRC*GCNT_W-1:0] gcnt_bus,
  input  logic [GCNT_W-1:0]          start_cnt,
  output logic                       start_evt
);
  logic [PHASE_W-1:0] line_q;
  logic [PHASE_W-1:0] line_hit;
  logic [GCNT_W-1:0]  gval;
  logic               frame_ok;
  logic               gcnt_ok;

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= line_phase;
  end

  // one detector per line phase
  for (genvar i = 0; i < PHASE_W; i++) begin : g_line
    assign line_hit[i] = start_mask[PHASE_W+i] & line_phase[i] & ~line_q[i];
  end

  assign gval     = gcnt_bus[int'(gsel[2:0])*GCNT_W +: GCNT_W];
  assign frame_ok = |(frame_phase & start_mask[PHASE_W-1:0]);
  assign gcnt_ok  = gsel[GSEL_W-1] | (gval == start_cnt);
  assign start_evt = (|line_hit) & frame_ok & gcnt_ok;
endmodule

// File: rtl/pgen_tick.sv
module pgen_tick
  import pgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] tick_sel,
  input  logic       pix_stb,
  input  logic       line_start,
  input  logic       frame_start,
  input  logic       peer_bit,
  output logic       tick
);
  logic peer_q;

  always_ff @(posedge clk) begin
    if (rst) peer_q <= 1'b0;
    else     peer_q <= peer_bit;
  end

  always_comb begin
    unique case (tick_src_e'(tick_sel))
      TICK_PIX:   tick = pix_stb;
      TICK_LINE:  tick = line_start;
      TICK_FRAME: tick = frame_start;
      default:    tick = peer_bit & ~peer_q;
    endcase
  end
endmodule

// File: rtl/pgen_core.sv
module pgen_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start_evt,
  input  logic             tick,
  input  logic [CNT_W-1:0] set_cnt,
  input  logic [CNT_W-1:0] clr_cnt,
  output logic             running,
  output logic [CNT_W-1:0] cnt,
  output logic             raw_q,
  output logic             start_pt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      running    <= 1'b0;
      cnt        <= '0;
      raw_q      <= 1'b0;
      start_pt_q <= 1'b0;
    end else begin
      start_pt_q <= start_evt && !running;
      if (running) begin
        if (cnt == clr_cnt) begin
          running <= 1'b0;
          cnt     <= '0;
          raw_q   <= 1'b0;
        end else begin
          if (cnt == set_cnt) raw_q <= 1'b1;
          if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
      end else if (start_evt) begin
        running <= 1'b1;
        cnt     <= '0;
      end
    end
  end

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!running && cnt == '0)); // R9
  AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (rst)
    (en && running && cnt == clr_cnt) |=> (!running && !raw_q)); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && running && cnt == CNT_MAX && cnt != clr_cnt) |=> (cnt == CNT_MAX)); // R6
  AST_START_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(start_evt)); // R2
endmodule

// File: rtl/pgen_top.sv
module pgen_top
  import pgen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int GCNT_W = 12,
  parameter int PSEL_W = 5,
  localparam int NPEER = 1 << PSEL_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pix_stb,
  input  logic                       line_start,
  input  logic                       frame_start,
  input  logic [PHASE_W-1:0]         frame_phase,
  input  logic [PHASE_W-1:0]         line_phase,
  input  logic [NUM_GSRC*GCNT_W-1:0] gcnt_bus,
  input  logic [NPEER-1:0]           peer_sig,
  input  logic                       cfg_en,
  input  logic                       cfg_pol,
  input  logic [1:0]                 cfg_tick,
  input  logic [GSEL_W-1:0]          cfg_gsel,
  input  logic [GCNT_W-1:0]          cfg_start_cnt,
  input  logic [2*PHASE_W-1:0]       cfg_start_mask,
  input  logic [CNT_W-1:0]           cfg_set,
  input  logic [CNT_W-1:0]           cfg_clr,
  input  logic [1:0]                 cfg_mix,
  input  logic [PSEL_W-1:0]          cfg_peer_sel,
  output logic                       sig_out
);
  logic             peer_bit;
  logic             start_evt;
  logic             tick;
  logic             running;
  logic [CNT_W-1:0] cnt;
  logic             raw_q;
  logic             start_pt_q;
  logic             mixed;

  assign peer_bit = peer_sig[cfg_peer_sel];

  pgen_arm #(.GCNT_W(GCNT_W)) u_arm (
    .clk(clk), .rst(rst), .frame_phase(frame_phase), .line_phase(line_phase),
    .start_mask(cfg_start_mask), .gsel(cfg_gsel), .gcnt_bus(gcnt_bus),
    .start_cnt(cfg_start_cnt), .start_evt(start_evt)
  );

  pgen_tick u_tick (
    .clk(clk), .rst(rst), .tick_sel(cfg_tick), .pix_stb(pix_stb),
    .line_start(line_start), .frame_start(frame_start), .peer_bit(peer_bit),
    .tick(tick)
  );

  pgen_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en(cfg_en), .start_evt(start_evt), .tick(tick),
    .set_cnt(cfg_set), .clr_cnt(cfg_clr), .running(running), .cnt(cnt),
    .raw_q(raw_q), .start_pt_q(start_pt_q)
  );

  always_comb begin
    unique case (mix_op_e'(cfg_mix))
      MIX_PASS: mixed = peer_bit;
      MIX_AND:  mixed = raw_q & peer_bit;
      MIX_OR:   mixed = raw_q | peer_bit;
      default:  mixed = start_pt_q & peer_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !cfg_en) sig_out <= ~cfg_pol;
    else                sig_out <= cfg_pol ? mixed : ~mixed;
  end

  AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (sig_out == !$past(cfg_pol))); // R9
  AST_AND_LOW_PEER: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_pol && cfg_mix == 2'd1 && !peer_bit) |=> !sig_out); // R7
endmodule

// File: tb/sim_pgen_top.sv
`timescale 1ns/1ps
module sim_pgen_top;
  localparam int GW = 12;
  localparam logic [3:0] PH_SYNC = 4'b0001, PH_BEGIN = 4'b0010, PH_DATA = 4'b0100;

  logic clk = 0, rst = 1;
  logic pix_stb = 0, line_start = 0, frame_start = 0;
  logic [3:0] frame_phase = 0, line_phase = 0;
  logic [8*GW-1:0] gcnt_bus = '0;
  logic [31:0] peer_sig = '0;
  logic cfg_en = 0, cfg_pol = 1;
  logic [1:0] cfg_tick = 0, cfg_mix = 0;
  logic [3:0] cfg_gsel = 4'd8;
  logic [11:0] cfg_start_cnt = 0;
  logic [7:0] cfg_start_mask = 0;
  logic [15:0] cfg_set = 0, cfg_clr = 0;
  logic [4:0] cfg_peer_sel = 0;
  logic sig_out;

  int n_chk = 0, n_err = 0;
  bit done = 0, ls_run = 0;

  always #5 clk = ~clk;

  pgen_top u0 (
    .clk(clk), .rst(rst), .pix_stb(pix_stb), .line_start(line_start),
    .frame_start(frame_start), .frame_phase(frame_phase), .line_phase(line_phase),
    .gcnt_bus(gcnt_bus), .peer_sig(peer_sig), .cfg_en(cfg_en), .cfg_pol(cfg_pol),
    .cfg_tick(cfg_tick), .cfg_gsel(cfg_gsel), .cfg_start_cnt(cfg_start_cnt),
    .cfg_start_mask(cfg_start_mask), .cfg_set(cfg_set), .cfg_clr(cfg_clr),
    .cfg_mix(cfg_mix), .cfg_peer_sel(cfg_peer_sel), .sig_out(sig_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model of the requirements, stepped once per clock
  logic [3:0] m_lq; logic m_pq, m_run, m_raw, m_sp, m_out; logic [15:0] m_cnt;
  always @(posedge clk) begin
    bit pb, st, tk, mx; logic [3:0] rise; logic [11:0] gv;
    pb = peer_sig[cfg_peer_sel];
    if (rst) begin
      m_lq = 0; m_pq = 0; m_run = 0; m_raw = 0; m_sp = 0; m_cnt = 0; m_out = !cfg_pol;
    end else begin
      case (cfg_mix)
        2'd0: mx = pb;
        2'd1: mx = m_raw & pb;
        2'd2: mx = m_raw | pb;
        default: mx = m_sp & pb;
      endcase
      m_out = !cfg_en ? !cfg_pol : (cfg_pol ? mx : !mx);
      rise = line_phase & ~m_lq;
      gv = gcnt_bus[int'(cfg_gsel[2:0])*GW +: GW];
      st = (|(cfg_start_mask[7:4] & rise)) && (|(cfg_start_mask[3:0] & frame_phase))
           && (cfg_gsel[3] || gv == cfg_start_cnt);
      case (cfg_tick)
        2'd0: tk = pix_stb;
        2'd1: tk = line_start;
        2'd2: tk = frame_start;
        default: tk = pb & !m_pq;
      endcase
      m_lq = line_phase; m_pq = pb;
      if (!cfg_en) begin
        m_run = 0; m_cnt = 0; m_raw = 0; m_sp = 0;
      end else begin
        m_sp = st && !m_run;
        if (m_run) begin
          if (m_cnt == cfg_clr) begin m_run = 0; m_cnt = 0; m_raw = 0; end
          else begin
            if (m_cnt == cfg_set) m_raw = 1;
            if (tk && m_cnt != 16'hFFFF) m_cnt = m_cnt + 1;
          end
        end else if (st) begin m_run = 1; m_cnt = 0; end
      end
    end
  end

  // cycle-level comparison against the model (covers R2..R10 under random stimulus)
  always @(negedge clk) if (!rst && !done) chk(sig_out == m_out, "R5 model", sig_out, m_out);

  task automatic count_high(input int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); if (sig_out) hi++; end
  endtask

  task automatic quiesce();
    @(negedge clk); cfg_en = 0; line_phase = PH_SYNC; peer_sig = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic base_cfg();
    cfg_pol = 1; cfg_tick = 2'd0; cfg_gsel = 4'd8; cfg_start_cnt = 0;
    cfg_start_mask = 8'b0010_0100; cfg_set = 16'd3; cfg_clr = 16'd6;
    cfg_mix = 2'd2; cfg_peer_sel = 0; peer_sig = '0; pix_stb = 1;
    frame_phase = PH_DATA; line_phase = PH_SYNC; cfg_en = 1;
    @(negedge clk);
  endtask

  task automatic fire_start();
    line_phase = PH_SYNC; repeat (2) @(negedge clk);
    line_phase = PH_BEGIN; @(negedge clk);
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      done = 1; n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int hi;
    void'($urandom(32'd2024));
    cfg_pol = 1;
    repeat (3) @(negedge clk);
    chk(sig_out == 1'b0, "R1 reset inactive pol=1", sig_out, 0);
    cfg_pol = 0; @(negedge clk);
    chk(sig_out == 1'b1, "R1 reset inactive pol=0", sig_out, 1);
    rst = 0;

    // R5 basic pulse, width clr-set
    quiesce(); base_cfg(); fire_start(); count_high(30, hi);
    chk(hi == 3, "R5 pulse width", hi, 3);
    // R6 re-arm
    fire_start(); count_high(30, hi);
    chk(hi == 3, "R6 re-arm second pulse", hi, 3);
    // R6 start while running ignored
    fire_start(); fire_start(); count_high(40, hi);
    chk(hi == 3, "R6 no restart while running", hi, 3);
    // R2 frame phase not selected
    quiesce(); base_cfg(); frame_phase = PH_SYNC; fire_start(); count_high(30, hi);
    chk(hi == 0, "R2 frame mask blocks", hi, 0);
    // R2 line phase not selected
    quiesce(); base_cfg(); cfg_start_mask = 8'b0100_0100; fire_start(); count_high(30, hi);
    chk(hi == 0, "R2 line mask blocks", hi, 0);
    // R3 global counter mismatch then match
    quiesce(); base_cfg(); cfg_gsel = 4'd0; cfg_start_cnt = 12'd7; gcnt_bus = '0;
    gcnt_bus[11:0] = 12'd5; fire_start(); count_high(30, hi);
    chk(hi == 0, "R3 gcnt mismatch", hi, 0);
    gcnt_bus[11:0] = 12'd7; fire_start(); count_high(30, hi);
    chk(hi == 3, "R3 gcnt match", hi, 3);
    gcnt_bus = '0;
    // R4 tick on line start every 10 cycles
    quiesce(); base_cfg(); cfg_tick = 2'd1; pix_stb = 0; ls_run = 1;
    fork
      while (ls_run) begin
        line_start = 1; @(negedge clk); line_start = 0; repeat (9) @(negedge clk);
      end
    join_none
    fire_start(); count_high(80, hi);
    chk(hi == 30, "R4 line tick width", hi, 30);
    ls_run = 0; repeat (12) @(negedge clk);
    // R4 pixel tick with no strobes never reaches set
    quiesce(); base_cfg(); pix_stb = 0; fire_start(); count_high(30, hi);
    chk(hi == 0, "R4 no tick no pulse", hi, 0);
    // R10 active low
    quiesce(); base_cfg(); cfg_pol = 0; @(negedge clk); fire_start(); count_high(30, hi);
    chk(hi == 27, "R10 active low pulse", hi, 27);
    // R9 disabled
    quiesce(); base_cfg(); cfg_en = 0; cfg_pol = 0; @(negedge clk); count_high(20, hi);
    chk(hi == 20, "R9 disabled inactive high", hi, 20);
    cfg_pol = 1; @(negedge clk); fire_start(); count_high(20, hi);
    chk(hi == 0, "R9 disabled ignores start", hi, 0);
    // R7 mix codes
    quiesce(); base_cfg(); cfg_mix = 2'd0; peer_sig[0] = 1; repeat (2) @(negedge clk);
    count_high(10, hi); chk(hi == 10, "R7 pass neighbour", hi, 10);
    cfg_mix = 2'd1; repeat (2) @(negedge clk); count_high(10, hi);
    chk(hi == 0, "R7 and with idle generator", hi, 0);
    cfg_mix = 2'd3; fire_start(); count_high(20, hi);
    chk(hi == 1, "R7 start marker and", hi, 1);
    // R8 neighbour select
    quiesce(); base_cfg(); cfg_mix = 2'd0; cfg_peer_sel = 5'd17; peer_sig = 32'h0002_0000;
    repeat (2) @(negedge clk); count_high(10, hi);
    chk(hi == 10, "R8 selected neighbour high", hi, 10);
    peer_sig = ~32'h0002_0000; repeat (2) @(negedge clk); count_high(10, hi);
    chk(hi == 0, "R8 other neighbours ignored", hi, 0);

    // constrained random episodes against the model
    for (int ep = 0; ep < 60; ep++) begin
      @(negedge clk);
      cfg_en = ($urandom % 8) != 0; cfg_pol = $urandom; cfg_tick = $urandom;
      cfg_gsel = $urandom; cfg_start_cnt = $urandom % 4; cfg_start_mask = $urandom;
      cfg_set = $urandom % 12; cfg_clr = $urandom % 12; cfg_mix = $urandom;
      cfg_peer_sel = $urandom;
      for (int c = 0; c < 400; c++) begin
        @(negedge clk);
        pix_stb = $urandom; line_start = ($urandom % 8) == 0;
        frame_start = ($urandom % 32) == 0;
        if (($urandom % 4) == 0) line_phase = 4'b0001 << ($urandom % 4);
        if (($urandom % 16) == 0) frame_phase = 4'b0001 << ($urandom % 4);
        for (int k = 0; k < 8; k++) gcnt_bus[k*GW +: GW] = $urandom % 4;
        peer_sig = $urandom;
      end
    end

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule